// File: doc/BRIEF.md
# Supply Undervoltage Monitor with Latched Status

This block watches four supply-good comparators: the field supply, the logic supply, the I/O supply and an optional low-voltage regulator. Each comparator flag is 1 while its supply is below its threshold. The block first brings each flag into the clock domain, then requires it to hold steady for a set number of cycles. From the qualified flags it drives an undervoltage output, an enable for the output drivers, a small status word and an active-low interrupt line.

The field, logic and I/O supplies are always watched. The regulator always records its own event, but it adds to the undervoltage output only when the mode input allows it. Status and interrupt bits stay latched after a fault has gone until software reads the status word. A read clears only those latched bits whose fault is no longer present. While the logic or I/O supply is low, the register interface is unusable: reads have no effect and the interrupt line is held inactive.

Top module: `supply_uv_monitor`

## Requirements
- R1: While reset is held, the block drives uv_o=1, drv_en_o=0, irq_n_o=1, bus_ok_o=0 and stat_o=3'b001, because every supply is taken to be low.
- R2: Each comparator flag passes through SYNC_STAGES flops. It takes effect only after it has differed from the current qualified value for FILT_CYCLES consecutive cycles, so shorter pulses change no output.
- R3: uv_o is 1 exactly while the qualified field, logic or I/O flag is set, or while the qualified regulator flag is set and reg_uv_en_i is 1.
- R4: After reset, drv_en_o stays 0 until uv_o has first gone low. From then on drv_en_o is 0 exactly while a qualified field, logic or I/O flag is set. A regulator fault alone never turns it off.
- R5: stat_o[0] shows the live qualified field flag. stat_o[1] latches one cycle after that flag is seen set.
- R6: stat_o[2] latches when the qualified regulator flag is set, whatever the value of reg_uv_en_i.
- R7: A one-cycle rd_stat_i while bus_ok_o is 1 clears each latched bit whose qualified flag is clear. A latched bit whose flag is still set stays 1.
- R8: bus_ok_o is 0 while the qualified logic or I/O flag is set. In that state irq_n_o is 1, rd_stat_i is ignored and drv_en_o is 0. Otherwise irq_n_o is 0 exactly while stat_o[1] or stat_o[2] is set.
- R9: Without a qualifying read, a latched status bit stays set after its fault has gone, while uv_o and drv_en_o follow the recovered supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uv_field_i | input | 1 | Field supply below threshold |
| uv_logic_i | input | 1 | Logic supply below threshold |
| uv_io_i | input | 1 | I/O supply below threshold |
| uv_reg_i | input | 1 | Regulator output below threshold |
| reg_uv_en_i | input | 1 | Mode bit: let the regulator drive uv_o |
| rd_stat_i | input | 1 | Status read strobe, one cycle |
| uv_o | output | 1 | Undervoltage indication, active high |
| drv_en_o | output | 1 | Output driver enable |
| irq_n_o | output | 1 | Interrupt, active low |
| bus_ok_o | output | 1 | Register interface usable |
| stat_o | output | 3 | {regulator latched, field latched, field live} |

## Verification
The assertions assume that rd_stat_i is a single-cycle strobe and that reg_uv_en_i is a synchronous register bit. The comparator flags may change in any cycle, because the synchronizer and the filter absorb them. The stimulus drives every input on the falling edge and pulses the read strobe for one cycle only. Its directed sequences hold each level well past SYNC_STAGES+FILT_CYCLES cycles, except for the glitch case, which is deliberately shorter than the filter window. A random phase then changes the flags at arbitrary times, and every cycle is compared against a behavioural model.

// File: rtl/svmon_pkg.sv
package svmon_pkg;
   localparam int NSUP      = 4;
   localparam int IDX_FIELD = 0;
   localparam int IDX_LOGIC = 1;
   localparam int IDX_IO    = 2;
   localparam int IDX_REG   = 3;

   // index of each latched bit inside the sticky array
   localparam int NLATCH    = 2;
   localparam int LAT_FIELD = 0;
   localparam int LAT_REG   = 1;

   typedef struct packed {
      logic reg_int;
      logic field_int;
      logic field_live;
   } svmon_stat_t;
endpackage

// File: rtl/svmon_sync.sv
module svmon_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/svmon_filter.sv
module svmon_filter #(
   parameter int               WIDTH   = 4,
   parameter int               CYCLES  = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int            CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [CW-1:0] cnt;
         logic          val;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
               val <= RST_VAL[b];
            end else if (d[b] != val) begin
               if (cnt == LAST) begin
                  cnt <= '0;
                  val <= d[b];
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               cnt <= '0;
            end
         end
         assign q[b] = val;
      end
   endgenerate
endmodule

// File: rtl/svmon_sticky.sv
module svmon_sticky #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_lvl,
   input  logic             clr,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_lvl[b] | (bit_q & ~clr);
         end
         assign q[b] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/supply_uv_monitor.sv
module supply_uv_monitor
   import svmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uv_field_i,
   input  logic       uv_logic_i,
   input  logic       uv_io_i,
   input  logic       uv_reg_i,
   input  logic       reg_uv_en_i,
   input  logic       rd_stat_i,
   output logic       uv_o,
   output logic       drv_en_o,
   output logic       irq_n_o,
   output logic       bus_ok_o,
   output logic [2:0] stat_o
);
   localparam logic [NSUP-1:0] ALL_LOW = '1;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (FILT_CYCLES < 1 || FILT_CYCLES > 65535) begin : g_bad_filt
         $error("FILT_CYCLES must lie in 1..65535");
      end
   endgenerate

   logic [NSUP-1:0] raw, synced, qual;
   assign raw[IDX_FIELD] = uv_field_i;
   assign raw[IDX_LOGIC] = uv_logic_i;
   assign raw[IDX_IO]    = uv_io_i;
   assign raw[IDX_REG]   = uv_reg_i;

   svmon_sync #(.WIDTH(NSUP), .STAGES(SYNC_STAGES), .RST_VAL(ALL_LOW)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

   svmon_filter #(.WIDTH(NSUP), .CYCLES(FILT_CYCLES), .RST_VAL(ALL_LOW)) u_filt (
      .clk(clk), .rst_n(rst_n), .d(synced), .q(qual));

   logic core_low, bus_ok, uv_any, clr;
   assign core_low = qual[IDX_FIELD] | qual[IDX_LOGIC] | qual[IDX_IO];
   assign bus_ok   = ~(qual[IDX_LOGIC] | qual[IDX_IO]);
   assign uv_any   = core_low | (qual[IDX_REG] & reg_uv_en_i);
   assign clr      = rd_stat_i & bus_ok;

   logic [NLATCH-1:0] lat_set, lat_q;
   assign lat_set[LAT_FIELD] = qual[IDX_FIELD];
   assign lat_set[LAT_REG]   = qual[IDX_REG];

   svmon_sticky #(.WIDTH(NLATCH)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_lvl(lat_set), .clr(clr), .q(lat_q));

   // power-up gate: opens the first time no monitored supply is low
   logic pu_done;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pu_done <= 1'b0;
      else        pu_done <= pu_done | ~uv_any;
   end

   svmon_stat_t st;
   assign st.field_live = qual[IDX_FIELD];
   assign st.field_int  = lat_q[LAT_FIELD];
   assign st.reg_int    = lat_q[LAT_REG];

   assign uv_o     = uv_any;
   assign drv_en_o = (pu_done | ~uv_any) & ~core_low;
   assign irq_n_o  = bus_ok ? ~(|lat_q) : 1'b1;
   assign bus_ok_o = bus_ok;
   assign stat_o   = st;
endmodule

// File: rtl/supply_uv_monitor_chk.sv
module supply_uv_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_uv_en_i,
   input logic       rd_stat_i,
   input logic       uv_o,
   input logic       drv_en_o,
   input logic       irq_n_o,
   input logic       bus_ok_o,
   input logic [2:0] stat_o
);
   // R3
   live_field_raises_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] |-> uv_o);
   // R4
   drv_implies_no_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o && !reg_uv_en_i) |-> !uv_o);
   // R5
   field_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] |=> stat_o[1]);
   // R7
   read_clears_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat_i && bus_ok_o && !stat_o[0]) |=> !stat_o[1]);
   // R8
   bus_down_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ok_o |-> (irq_n_o && !drv_en_o));
   // R9
   field_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[1] && !(rd_stat_i && bus_ok_o)) |=> stat_o[1]);
   // R9
   reg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[2] && !(rd_stat_i && bus_ok_o)) |=> stat_o[2]);
endmodule

bind supply_uv_monitor supply_uv_monitor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_uv_en_i(reg_uv_en_i), .rd_stat_i(rd_stat_i),
   .uv_o(uv_o), .drv_en_o(drv_en_o), .irq_n_o(irq_n_o), .bus_ok_o(bus_ok_o),
   .stat_o(stat_o));

// File: tb/supply_uv_monitor_bench.sv
module supply_uv_monitor_bench;
   localparam int SYNC = 2;
   localparam int FILT = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic f_i = 1, l_i = 1, io_i = 1, r_i = 1, en_i = 1, rd_i = 0;
   logic uv, drv, irqn, busok;
   logic [2:0] stat;
   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   supply_uv_monitor #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT)) u_supply_uv_monitor (
      .clk(clk), .rst_n(rst_n), .uv_field_i(f_i), .uv_logic_i(l_i), .uv_io_i(io_i),
      .uv_reg_i(r_i), .reg_uv_en_i(en_i), .rd_stat_i(rd_i), .uv_o(uv),
      .drv_en_o(drv), .irq_n_o(irqn), .bus_ok_o(busok), .stat_o(stat));

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: delay queue, per-supply stability counters, latches
   logic [3:0] mq[$];
   bit mf[4];
   int mc[4];
   bit mfi, mri, mpu;

   function automatic bit m_uv();
      return mf[0] | mf[1] | mf[2] | (mf[3] & en_i);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         for (int k = 0; k < SYNC; k++) mq.push_back(4'hF);
         for (int b = 0; b < 4; b++) begin mf[b] = 1; mc[b] = 0; end
         mfi = 0; mri = 0; mpu = 0;
      end else begin
         logic [3:0] so;
         bit clr;
         so  = (SYNC == 0) ? {r_i, io_i, l_i, f_i} : mq[0];
         clr = rd_i && !(mf[1] || mf[2]);
         mfi = mf[0] | (mfi & !clr);
         mri = mf[3] | (mri & !clr);
         mpu = mpu | !m_uv();
         for (int b = 0; b < 4; b++) begin
            if (so[b] != mf[b]) begin
               if (mc[b] == FILT - 1) begin mf[b] = so[b]; mc[b] = 0; end
               else mc[b]++;
            end else mc[b] = 0;
         end
         if (SYNC > 0) begin
            void'(mq.pop_front());
            mq.push_back({r_i, io_i, l_i, f_i});
         end
      end
      #1;
      if (rst_n && !done) begin
         bit core;
         core = mf[0] | mf[1] | mf[2];
         chk("R3 uv_o model", uv, m_uv());
         chk("R4 drv_en_o model", drv, (mpu | !m_uv()) & !core);
         chk("R8 bus_ok_o model", busok, !(mf[1] | mf[2]));
         chk("R8 irq_n_o model", irqn, (mf[1] | mf[2]) ? 1 : !(mfi | mri));
         chk("R5 R6 R7 R9 stat_o model", stat, {mri, mfi, mf[0]});
      end
   end

   task automatic waitc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic read_pulse();
      @(negedge clk) rd_i = 1;
      @(negedge clk) rd_i = 0;
      waitc(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      waitc(4);
      // R1 reset state
      chk("R1 uv_o", uv, 1);
      chk("R1 drv_en_o", drv, 0);
      chk("R1 irq_n_o", irqn, 1);
      chk("R1 bus_ok_o", busok, 0);
      chk("R1 stat_o", stat, 3'b001);
      @(negedge clk) rst_n = 1;
      waitc(5);
      // core supplies recover, regulator still low with mode enabled
      @(negedge clk) begin f_i = 0; l_i = 0; io_i = 0; end
      waitc(20);
      chk("R4 drv held before first good", drv, 0);
      chk("R3 reg counts when enabled", uv, 1);
      @(negedge clk) r_i = 0;
      waitc(20);
      chk("R4 drv after power-up", drv, 1);
      chk("R3 uv released", uv, 0);
      chk("R9 sticky after recovery", stat, 3'b110);
      chk("R8 irq asserted", irqn, 0);
      read_pulse();
      chk("R7 read clears", stat, 3'b000);
      chk("R8 irq released", irqn, 1);
      // glitch shorter than the filter window
      @(negedge clk) f_i = 1;
      @(negedge clk) f_i = 0;
      waitc(20);
      chk("R2 glitch ignored stat", stat, 3'b000);
      chk("R2 glitch ignored uv", uv, 0);
      // field fault
      @(negedge clk) f_i = 1;
      waitc(20);
      chk("R5 field live+latched", stat, 3'b011);
      chk("R4 drv off on field", drv, 0);
      @(negedge clk) f_i = 0;
      waitc(20);
      chk("R9 field held", stat, 3'b010);
      chk("R9 drv back", drv, 1);
      read_pulse();
      chk("R7 field cleared", stat, 3'b000);
      // regulator fault with mode disabled
      @(negedge clk) begin en_i = 0; r_i = 1; end
      waitc(20);
      chk("R6 reg latched", stat, 3'b100);
      chk("R3 reg masked", uv, 0);
      @(negedge clk) en_i = 1;
      waitc(1);
      chk("R3 reg unmasked", uv, 1);
      chk("R4 reg no drv effect", drv, 1);
      read_pulse();
      chk("R7 active fault kept", stat, 3'b100);
      @(negedge clk) r_i = 0;
      waitc(20);
      read_pulse();
      chk("R7 reg cleared", stat, 3'b000);
      // logic-supply fault blocks the interface
      @(negedge clk) f_i = 1;
      waitc(20);
      @(negedge clk) l_i = 1;
      waitc(20);
      chk("R8 bus down", busok, 0);
      chk("R8 irq idle", irqn, 1);
      @(negedge clk) f_i = 0;
      waitc(20);
      read_pulse();
      chk("R8 read ignored", stat, 3'b010);
      @(negedge clk) l_i = 0;
      waitc(20);
      chk("R8 irq after bus back", irqn, 0);
      read_pulse();
      chk("R7 cleared after bus back", stat, 3'b000);
      // I/O-supply fault
      @(negedge clk) io_i = 1;
      waitc(20);
      chk("R8 io bus down", busok, 0);
      chk("R4 io drv off", drv, 0);
      @(negedge clk) io_i = 0;
      waitc(20);
      // random phase, compared each cycle against the model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         f_i  = ($urandom_range(0, 9) == 0) ? ~f_i : f_i;
         l_i  = ($urandom_range(0, 19) == 0) ? ~l_i : l_i;
         io_i = ($urandom_range(0, 19) == 0) ? ~io_i : io_i;
         r_i  = ($urandom_range(0, 9) == 0) ? ~r_i : r_i;
         en_i = ($urandom_range(0, 29) == 0) ? ~en_i : en_i;
         rd_i = ($urandom_range(0, 7) == 0);
      end
      @(negedge clk) rd_i = 0;
      waitc(2);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule